// File: doc/BRIEF.md
# MSI Enable Edge Capture Unit

This block sits in a PCIe endpoint function. It holds the message-signalled interrupt settings that configuration software writes: the doorbell address, the message data, the MSI enable bit and the MSI-X enable bit. The interrupt path does not read these configuration registers on every cycle. It works from a private shadow copy of address and data. That copy is loaded only on the clock where MSI enable is written from 0 to 1. After that the shadow is not read from the configuration registers again until software clears MSI enable and sets it once more. This is how software applies a new doorbell or message value, for example after moving an interrupt to another processor.

Internal logic raises interrupt events per vector. While MSI is permitted (MSI enable 1, MSI-X enable 0), pending vectors go out one at a time. Each one is a write descriptor that carries the single doorbell address and a data word that names the vector, and it is handed over through a valid/ready handshake. Otherwise the pending vectors drive a level-style legacy INTx line. A write to address or data while MSI is enabled leaves the shadow unchanged and sets a sticky stale flag, which is cleared by the next capture.

Top module: `msi_edge_capture`

## Requirements
- R1: After reset both enable bits, the shadow address and data, and the stale flag are 0. `msg_valid_o` and `intx_o` are low.
- R2: Control write data bit 0 is MSI enable and bit 1 is MSI-X enable. On the clock where a control write sets MSI enable while it is currently 0, the shadow copies load the configured address and data, and the stale flag clears.
- R3: If an address or data write lands on the same clock as that 0-to-1 write, the shadow takes the newly written value.
- R4: An address or data write while MSI enable is 1 leaves the shadow unchanged and sets `stale_o`. The flag stays set until the next capture. Writes while MSI enable is 0 do not set it.
- R5: Clearing MSI enable, writing new values and setting MSI enable again makes later messages carry the new values.
- R6: `msg_valid_o` is high only while MSI enable is 1 and MSI-X enable is 0. `msg_addr_o` is the shadow address. `msg_data_o` is the shadow data with its low log2(N_VEC) bits replaced by the vector index.
- R7: Once `msg_valid_o` is high, it stays high and the message stays stable until `msg_ready_i` is seen, unless MSI stops being permitted. An accepted message clears that vector's pending bit, and the vector is not sent again.
- R8: When several vectors are pending, the lowest index is sent first.
- R9: While MSI is permitted, `intx_o` is never high. Otherwise `intx_o` is high exactly while any vector is pending, and `irq_clr_i` removes pending vectors.
- R10: With MSI-X enable set, requests route to INTx even when MSI enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ctrl_we_i | input | 1 | Write strobe for the control register |
| cfg_ctrl_wdata_i | input | 2 | Control data: bit 0 MSI enable, bit 1 MSI-X enable |
| cfg_addr_we_i | input | 1 | Write strobe for the message address |
| cfg_addr_wdata_i | input | ADDR_W | Message address write data |
| cfg_data_we_i | input | 1 | Write strobe for the message data |
| cfg_data_wdata_i | input | DATA_W | Message data write data |
| irq_set_i | input | N_VEC | Per-vector event pulses that set pending |
| irq_clr_i | input | N_VEC | Per-vector clears of pending |
| msg_valid_o | output | 1 | MSI write descriptor is valid |
| msg_ready_i | input | 1 | Downstream accepts the descriptor |
| msg_addr_o | output | ADDR_W | Descriptor doorbell address |
| msg_data_o | output | DATA_W | Descriptor data, with the vector in the low bits |
| intx_o | output | 1 | Legacy interrupt level |
| stale_o | output | 1 | Sticky flag: configuration written after capture |

## Verification
A wrong shadow register shows up only in the first descriptor sent after the bad load. That descriptor leaves two cycles after its event pulse, so the bench follows each capture scenario with a raised vector and compares the address and data. A wrong pending or slot state shows up as a repeated or missing descriptor, or as the INTx level being wrong on the cycle right after the update. A mode decode error shows immediately as INTx and a valid descriptor being active together. An error in the edge detector is hidden until the next event, so each enable sequence is probed with an interrupt rather than read back.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  typedef struct packed {
    logic msix_en;
    logic msi_en;
  } cap_ctrl_t;

  typedef enum logic {
    IRQ_ROUTE_INTX = 1'b0,
    IRQ_ROUTE_MSI  = 1'b1
  } irq_route_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  cap_ctrl_t         ctrl_wdata_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  output irq_route_e        route_o,
  output logic              msi_en_o,
  output logic [ADDR_W-1:0] shadow_addr_o,
  output logic [DATA_W-1:0] shadow_data_o,
  output logic              stale_o
);
  cap_ctrl_t         ctrl_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt, sh_addr_q;
  logic [DATA_W-1:0] data_q, data_nxt, sh_data_q;
  logic              stale_q, en_rise, cfg_touch;

  assign addr_nxt  = addr_we_i ? addr_wdata_i : addr_q;
  assign data_nxt  = data_we_i ? data_wdata_i : data_q;
  // edge taken from the write itself so a same-clock value write is captured
  assign en_rise   = ctrl_we_i & ctrl_wdata_i.msi_en & ~ctrl_q.msi_en;
  assign cfg_touch = (addr_we_i | data_we_i) & ctrl_q.msi_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      sh_addr_q <= '0;
      sh_data_q <= '0;
      stale_q   <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
      addr_q <= addr_nxt;
      data_q <= data_nxt;
      if (en_rise) begin
        sh_addr_q <= addr_nxt;
        sh_data_q <= data_nxt;
        stale_q   <= 1'b0;
      end else if (cfg_touch) begin
        stale_q   <= 1'b1;
      end
    end
  end

  assign route_o       = (ctrl_q.msi_en && !ctrl_q.msix_en) ? IRQ_ROUTE_MSI : IRQ_ROUTE_INTX;
  assign msi_en_o      = ctrl_q.msi_en;
  assign shadow_addr_o = sh_addr_q;
  assign shadow_data_o = sh_data_q;
  assign stale_o       = stale_q;
endmodule

// File: rtl/msi_pend_bank.sv
module msi_pend_bank #(
  parameter int unsigned N_VEC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_VEC-1:0] set_i,
  input  logic [N_VEC-1:0] clr_i,
  input  logic [N_VEC-1:0] done_i,
  output logic [N_VEC-1:0] pend_o
);
  logic [N_VEC-1:0] pend_q;

  for (genvar g = 0; g < N_VEC; g++) begin : g_bit
    // a fresh event wins over a clear on the same clock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      pend_q[g] <= 1'b0;
      else if (set_i[g])                pend_q[g] <= 1'b1;
      else if (clr_i[g] || done_i[g])   pend_q[g] <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/msi_msg_slot.sv
module msi_msg_slot
  import msi_cap_pkg::*;
#(
  parameter int unsigned N_VEC  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  irq_route_e        route_i,
  input  logic [N_VEC-1:0]  pend_i,
  input  logic [ADDR_W-1:0] shadow_addr_i,
  input  logic [DATA_W-1:0] shadow_data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [N_VEC-1:0]  done_o
);
  localparam int unsigned VEC_W = (N_VEC > 1) ? $clog2(N_VEC) : 1;

  logic             msi_ok, slot_vld_q, found, accept;
  logic [VEC_W-1:0] slot_vec_q, pick;

  assign msi_ok = (route_i == IRQ_ROUTE_MSI);

  always_comb begin
    pick  = '0;
    found = |pend_i;
    for (int i = N_VEC - 1; i >= 0; i--) begin
      if (pend_i[i]) pick = VEC_W'(i);
    end
  end

  assign valid_o = slot_vld_q & msi_ok;
  assign accept  = valid_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_vld_q <= 1'b0;
      slot_vec_q <= '0;
    end else if (!msi_ok) begin
      slot_vld_q <= 1'b0;
    end else if (accept) begin
      slot_vld_q <= 1'b0;
    end else if (!slot_vld_q && found) begin
      slot_vld_q <= 1'b1;
      slot_vec_q <= pick;
    end
  end

  for (genvar g = 0; g < N_VEC; g++) begin : g_done
    assign done_o[g] = accept && (slot_vec_q == VEC_W'(g));
  end

  assign addr_o = shadow_addr_i;
  if (DATA_W > VEC_W) begin : g_data_wide
    assign data_o = {shadow_data_i[DATA_W-1:VEC_W], slot_vec_q};
  end else begin : g_data_narrow
    assign data_o = slot_vec_q[DATA_W-1:0];
  end
endmodule

// File: rtl/msi_edge_capture.sv
module msi_edge_capture
  import msi_cap_pkg::*;
#(
  parameter int unsigned N_VEC  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_ctrl_we_i,
  input  logic [1:0]        cfg_ctrl_wdata_i,
  input  logic              cfg_addr_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_wdata_i,
  input  logic              cfg_data_we_i,
  input  logic [DATA_W-1:0] cfg_data_wdata_i,
  input  logic [N_VEC-1:0]  irq_set_i,
  input  logic [N_VEC-1:0]  irq_clr_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o,
  output logic              intx_o,
  output logic              stale_o
);
  irq_route_e        route;
  logic              msi_en, msi_mode;
  logic [ADDR_W-1:0] shadow_addr;
  logic [DATA_W-1:0] shadow_data;
  logic [N_VEC-1:0]  pend, done;

  msi_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctrl_we_i     (cfg_ctrl_we_i),
    .ctrl_wdata_i  (cap_ctrl_t'(cfg_ctrl_wdata_i)),
    .addr_we_i     (cfg_addr_we_i),
    .addr_wdata_i  (cfg_addr_wdata_i),
    .data_we_i     (cfg_data_we_i),
    .data_wdata_i  (cfg_data_wdata_i),
    .route_o       (route),
    .msi_en_o      (msi_en),
    .shadow_addr_o (shadow_addr),
    .shadow_data_o (shadow_data),
    .stale_o       (stale_o)
  );

  msi_pend_bank #(.N_VEC(N_VEC)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set_i),
    .clr_i  (irq_clr_i),
    .done_i (done),
    .pend_o (pend)
  );

  msi_msg_slot #(.N_VEC(N_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_slot (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .route_i       (route),
    .pend_i        (pend),
    .shadow_addr_i (shadow_addr),
    .shadow_data_i (shadow_data),
    .ready_i       (msg_ready_i),
    .valid_o       (msg_valid_o),
    .addr_o        (msg_addr_o),
    .data_o        (msg_data_o),
    .done_o        (done)
  );

  assign msi_mode = (route == IRQ_ROUTE_MSI);
  assign intx_o   = !msi_mode && (|pend);
endmodule

// File: rtl/msi_edge_capture_chk.sv
module msi_edge_capture_chk #(
  parameter int unsigned N_VEC  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_ctrl_we_i,
  input logic [1:0]        cfg_ctrl_wdata_i,
  input logic              cfg_addr_we_i,
  input logic              cfg_data_we_i,
  input logic              msi_en,
  input logic              msi_mode,
  input logic [ADDR_W-1:0] shadow_addr,
  input logic [DATA_W-1:0] shadow_data,
  input logic [N_VEC-1:0]  done,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [ADDR_W-1:0] msg_addr_o,
  input logic [DATA_W-1:0] msg_data_o,
  input logic              intx_o,
  input logic              stale_o
);
  assert_capture_clears_stale_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ctrl_we_i && cfg_ctrl_wdata_i[0] && !msi_en) |=> !stale_o);

  assert_shadow_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_en |=> $stable(shadow_addr) && $stable(shadow_data));

  assert_stale_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_addr_we_i || cfg_data_we_i) && msi_en) |=> stale_o);

  assert_msi_only_when_permitted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msi_mode);

  assert_msg_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=>
      (!msi_mode || (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o))));

  assert_single_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done));

  assert_no_intx_in_msi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_mode |-> !intx_o);
endmodule

bind msi_edge_capture msi_edge_capture_chk #(
  .N_VEC(N_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cfg_ctrl_we_i    (cfg_ctrl_we_i),
  .cfg_ctrl_wdata_i (cfg_ctrl_wdata_i),
  .cfg_addr_we_i    (cfg_addr_we_i),
  .cfg_data_we_i    (cfg_data_we_i),
  .msi_en           (msi_en),
  .msi_mode         (msi_mode),
  .shadow_addr      (shadow_addr),
  .shadow_data      (shadow_data),
  .done             (done),
  .msg_valid_o      (msg_valid_o),
  .msg_ready_i      (msg_ready_i),
  .msg_addr_o       (msg_addr_o),
  .msg_data_o       (msg_data_o),
  .intx_o           (intx_o),
  .stale_o          (stale_o)
);

// File: tb/test_msi_edge_capture.sv
module test_msi_edge_capture;
  localparam int unsigned N_VEC  = 4;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_ctrl_we_i = 1'b0;
  logic [1:0]        cfg_ctrl_wdata_i = '0;
  logic              cfg_addr_we_i = 1'b0;
  logic [ADDR_W-1:0] cfg_addr_wdata_i = '0;
  logic              cfg_data_we_i = 1'b0;
  logic [DATA_W-1:0] cfg_data_wdata_i = '0;
  logic [N_VEC-1:0]  irq_set_i = '0;
  logic [N_VEC-1:0]  irq_clr_i = '0;
  logic              msg_ready_i = 1'b0;
  logic              msg_valid_o, intx_o, stale_o;
  logic [ADDR_W-1:0] msg_addr_o;
  logic [DATA_W-1:0] msg_data_o;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #5 clk_i = ~clk_i;

  msi_edge_capture #(.N_VEC(N_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_msi_edge_capture (
    .clk_i, .rst_ni, .cfg_ctrl_we_i, .cfg_ctrl_wdata_i, .cfg_addr_we_i, .cfg_addr_wdata_i,
    .cfg_data_we_i, .cfg_data_wdata_i, .irq_set_i, .irq_clr_i, .msg_valid_o, .msg_ready_i,
    .msg_addr_o, .msg_data_o, .intx_o, .stale_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wr_ctrl(input logic [1:0] v);
    cfg_ctrl_we_i = 1'b1; cfg_ctrl_wdata_i = v;
    step();
    cfg_ctrl_we_i = 1'b0;
  endtask

  task automatic wr_vals(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cfg_addr_we_i = 1'b1; cfg_addr_wdata_i = a;
    cfg_data_we_i = 1'b1; cfg_data_wdata_i = d;
    step();
    cfg_addr_we_i = 1'b0; cfg_data_we_i = 1'b0;
  endtask

  // pulse events; after return the slot has had one edge to load
  task automatic raise(input logic [N_VEC-1:0] v);
    irq_set_i = v;
    step();
    irq_set_i = '0;
    step();
  endtask

  task automatic accept();
    msg_ready_i = 1'b1;
    step();
    msg_ready_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid", msg_valid_o, 0);
    chk("R1 intx", intx_o, 0);
    chk("R1 stale", stale_o, 0);
  endtask

  task automatic t_intx();
    raise(4'b0100);
    chk("R9 intx on pending", intx_o, 1);
    chk("R6 no msg while disabled", msg_valid_o, 0);
    irq_clr_i = 4'b0100; step(); irq_clr_i = '0;
    chk("R9 intx cleared", intx_o, 0);
  endtask

  task automatic t_capture();
    wr_vals(32'hFEE0_1000, 16'hAB00);
    chk("R4 no stale when disabled", stale_o, 0);
    wr_ctrl(2'b01);
    raise(4'b0010);
    chk("R6 valid", msg_valid_o, 1);
    chk("R2 addr captured", msg_addr_o, 32'hFEE0_1000);
    chk("R6 data with vector", msg_data_o, 16'hAB01);
    chk("R9 no intx in msi", intx_o, 0);
    step(); step();
    chk("R7 held valid", msg_valid_o, 1);
    chk("R7 held data", msg_data_o, 16'hAB01);
    accept();
    chk("R7 dropped after accept", msg_valid_o, 0);
    step();
    chk("R7 no resend", msg_valid_o, 0);
  endtask

  task automatic t_stale();
    wr_vals(32'hFEE0_2000, 16'hCD00);
    chk("R4 stale set", stale_o, 1);
    raise(4'b0001);
    chk("R4 old addr kept", msg_addr_o, 32'hFEE0_1000);
    chk("R4 old data kept", msg_data_o, 16'hAB00);
    accept();
    chk("R4 stale sticky", stale_o, 1);
  endtask

  task automatic t_reenable();
    wr_ctrl(2'b00);
    wr_ctrl(2'b01);
    chk("R2 stale cleared by capture", stale_o, 0);
    raise(4'b0001);
    chk("R5 new addr", msg_addr_o, 32'hFEE0_2000);
    chk("R5 new data", msg_data_o, 16'hCD00);
    accept();
  endtask

  task automatic t_same_clock();
    wr_ctrl(2'b00);
    cfg_ctrl_we_i = 1'b1; cfg_ctrl_wdata_i = 2'b01;
    cfg_addr_we_i = 1'b1; cfg_addr_wdata_i = 32'hFEE0_3000;
    cfg_data_we_i = 1'b1; cfg_data_wdata_i = 16'h5500;
    step();
    cfg_ctrl_we_i = 1'b0; cfg_addr_we_i = 1'b0; cfg_data_we_i = 1'b0;
    chk("R3 no stale on same clock", stale_o, 0);
    raise(4'b0001);
    chk("R3 same-clock addr", msg_addr_o, 32'hFEE0_3000);
    chk("R3 same-clock data", msg_data_o, 16'h5500);
    accept();
  endtask

  task automatic t_priority();
    raise(4'b1010);
    chk("R8 lowest first", msg_data_o, 16'h5501);
    accept();
    step();
    chk("R8 next valid", msg_valid_o, 1);
    chk("R8 next vector", msg_data_o, 16'h5503);
    accept();
    step();
    chk("R7 all drained", msg_valid_o, 0);
  endtask

  task automatic t_msix();
    wr_ctrl(2'b11);
    raise(4'b0001);
    chk("R10 intx with msix", intx_o, 1);
    chk("R10 no msg with msix", msg_valid_o, 0);
    irq_clr_i = 4'b0001; step(); irq_clr_i = '0;
    chk("R10 intx cleared", intx_o, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_intx();
    t_capture();
    t_stale();
    t_reenable();
    t_same_clock();
    t_priority();
    t_msix();
    done_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule